// File: doc/BRIEF.md
# Task Reservation Station Dispatcher

This block sits between a task dispatch stage and a set of hardware accelerators. The dispatch stage writes decoded tasks into a small pool of station entries. Each task carries a 4-bit task identifier, an 8-bit target accelerator number, and an optional producer task identifier. A task with a producer waits in its entry until that producer's identifier appears on a shared completion bus. A ready task is sent to its accelerator only when the block's own accelerator busy register shows that accelerator idle. Several tasks may leave in the same cycle, up to a design-time issue width.

When an accelerator finishes, it raises a completion request with the identifier of the task it ran. A ticket arbiter numbers these requests in the order they arrive, and simultaneous arrivals are numbered by ascending accelerator index. It then serves one ticket per cycle, lowest outstanding first. The served request is broadcast on the completion bus. That broadcast wakes every waiting entry whose producer matches, and it clears the finishing accelerator's busy bit. When every entry is occupied, a stall signal tells the dispatch stage to hold off.

Each station entry runs a small state machine. ENT_FREE moves to ENT_WAIT when it is written with a producer that is not being broadcast in that cycle. ENT_FREE moves to ENT_READY when it is written with no producer, or with a producer broadcast in that same cycle. ENT_WAIT moves to ENT_READY when a matching broadcast arrives. ENT_READY moves to ENT_FREE when the entry is issued. Each completion requester has its own machine. RQ_IDLE moves to RQ_HOLD when a request is seen and a ticket is taken. RQ_HOLD moves to RQ_IDLE when its ticket is served, which is the grant cycle.

Top module: `task_rs_dispatcher`

## Requirements
- R1: After reset no entry is held, `alloc_stall`, `acc_busy`, `issue_valid`, `done_grant` and `cdb_valid` are all zero.
- R2: A task written with no producer, whose target accelerator is idle, appears on issue slot 0 in the cycle after the write edge. It carries the task ID and accelerator number that were written. Both IDs are carried at their full widths of 4 and 8 bits.
- R3: A ready task whose target accelerator's busy bit is 1 is not issued. It issues in the cycle after the edge that clears that bit.
- R4: Issuing a task sets its target accelerator's busy bit at the edge that ends the issue cycle.
- R5: A task with a producer ID p stays unissued until a broadcast with `cdb_valid`=1 and `cdb_tid`=p occurs. A broadcast with any other ID leaves it waiting. It becomes issuable in the cycle after the matching broadcast.
- R6: If a matching broadcast occurs in the same cycle that a dependent task is written, the task is ready at once and issues in the next cycle.
- R7: A broadcast clears the busy bit of accelerator `cdb_aid` at the edge ending the broadcast cycle.
- R8: Up to ISSUE_W tasks leave per cycle. Slot 0 takes the lowest-numbered eligible entry and later slots take the next ones. Slots fill from slot 0 upward. No two slots target the same accelerator in one cycle. Remaining eligible entries wait for a later cycle.
- R9: `alloc_stall` is 1 exactly while every entry is occupied. A write offered while the stall is high is dropped: that task is never issued.
- R10: Completion requests are served one grant per cycle, in the order the tickets were taken. A request takes its ticket at the first edge at which it is seen. Requests first seen at the same edge are ordered by ascending accelerator index. A request whose ticket is next is granted in the cycle after that edge. The grant is a single-cycle pulse on `done_grant`. The bus then carries `cdb_tid` = that accelerator's `done_tid` and `cdb_aid` = its index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| alloc_valid | input | 1 | Dispatch stage offers a task |
| alloc_tid | input | TID_W | Task ID of the offered task |
| alloc_aid | input | AID_W | Target accelerator number |
| alloc_has_dep | input | 1 | Offered task waits on a producer |
| alloc_dep_tid | input | TID_W | Producer task ID |
| alloc_stall | output | 1 | All entries occupied; offer is dropped |
| issue_valid | output | ISSUE_W | Per-slot issue strobe |
| issue_tid | output | ISSUE_W*TID_W | Per-slot issued task ID |
| issue_aid | output | ISSUE_W*AID_W | Per-slot target accelerator |
| done_req | input | NUM_ACCEL | Per-accelerator completion request |
| done_tid | input | NUM_ACCEL*TID_W | Task ID finished by each accelerator |
| done_grant | output | NUM_ACCEL | Completion request served this cycle |
| cdb_valid | output | 1 | Completion bus broadcast valid |
| cdb_tid | output | TID_W | Broadcast task ID |
| cdb_aid | output | AID_W | Broadcast accelerator number |
| acc_busy | output | NUM_ACCEL | Accelerator busy register |

## Verification
The assertions rely on three properties of the inputs. Every accelerator number offered is below NUM_ACCEL. A requester drops `done_req` within its grant cycle and holds `done_tid` steady while it requests. No broadcast names an accelerator that is being issued to in that same cycle. The bench drives its model accelerators to respect these rules. It routes its free-standing wake-up broadcasts through an accelerator that no pending task targets. It sweeps every producer ID against every broadcast ID, and every set of simultaneous completion requests.

// File: rtl/rs_pkg.sv
package rs_pkg;

    // Life cycle of one station entry.
    typedef enum logic [1:0] {
        ENT_FREE  = 2'd0,
        ENT_WAIT  = 2'd1,
        ENT_READY = 2'd2
    } ent_state_e;

    // Life cycle of one completion requester in the ticket arbiter.
    typedef enum logic {
        RQ_IDLE = 1'b0,
        RQ_HOLD = 1'b1
    } req_state_e;

    localparam int DEF_TID_W = 4;
    localparam int DEF_AID_W = 8;

endpackage

// File: rtl/rs_entry.sv
module rs_entry
    import rs_pkg::*;
#(
    parameter int TID_W = DEF_TID_W,
    parameter int AID_W = DEF_AID_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [TID_W-1:0] wr_tid,
    input  logic [AID_W-1:0] wr_aid,
    input  logic             wr_has_dep,
    input  logic [TID_W-1:0] wr_dep,
    input  logic             cdb_valid,
    input  logic [TID_W-1:0] cdb_tid,
    input  logic             take,
    output logic             is_free,
    output logic             is_ready,
    output logic [TID_W-1:0] tid_q,
    output logic [AID_W-1:0] aid_q
);

    ent_state_e       state_q, state_d;
    logic [TID_W-1:0] dep_q;
    logic             load;
    logic             wake_now;

    assign load     = wr_en && (state_q == ENT_FREE);
    assign wake_now = cdb_valid && (cdb_tid == wr_dep);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ENT_FREE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ENT_FREE: begin
                if (wr_en) begin
                    state_d = (wr_has_dep && !wake_now) ? ENT_WAIT : ENT_READY;
                end
            end
            ENT_WAIT: begin
                if (cdb_valid && (cdb_tid == dep_q)) begin
                    state_d = ENT_READY;
                end
            end
            ENT_READY: begin
                if (take) begin
                    state_d = ENT_FREE;
                end
            end
            default: state_d = ENT_FREE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tid_q <= '0;
            aid_q <= '0;
            dep_q <= '0;
        end else if (load) begin
            tid_q <= wr_tid;
            aid_q <= wr_aid;
            dep_q <= wr_dep;
        end
    end

    always_comb begin
        is_free  = (state_q == ENT_FREE);
        is_ready = (state_q == ENT_READY);
    end

endmodule

// File: rtl/rs_issue_select.sv
module rs_issue_select #(
    parameter int ENTRIES   = 4,
    parameter int NUM_ACCEL = 4,
    parameter int ISSUE_W   = 2,
    parameter int TID_W     = 4,
    parameter int AID_W     = 8
) (
    input  logic [ENTRIES-1:0]       ready,
    input  logic [ENTRIES*TID_W-1:0] ent_tid,
    input  logic [ENTRIES*AID_W-1:0] ent_aid,
    input  logic [NUM_ACCEL-1:0]     busy,
    output logic [ENTRIES-1:0]       take,
    output logic [ISSUE_W-1:0]       issue_valid,
    output logic [ISSUE_W*TID_W-1:0] issue_tid,
    output logic [ISSUE_W*AID_W-1:0] issue_aid,
    output logic [NUM_ACCEL-1:0]     set_busy
);

    logic [NUM_ACCEL-1:0] tgt [ENTRIES];
    logic [ENTRIES-1:0]   eligible;

    for (genvar e = 0; e < ENTRIES; e++) begin : g_tgt
        for (genvar a = 0; a < NUM_ACCEL; a++) begin : g_acc
            assign tgt[e][a] = (ent_aid[e*AID_W +: AID_W] == AID_W'(a));
        end
        assign eligible[e] = ready[e] && (|(tgt[e] & ~busy));
    end

    always_comb begin
        logic                 found;
        logic [NUM_ACCEL-1:0] claimed;
        take        = '0;
        claimed     = '0;
        issue_valid = '0;
        issue_tid   = '0;
        issue_aid   = '0;
        for (int k = 0; k < ISSUE_W; k++) begin
            found = 1'b0;
            for (int e = 0; e < ENTRIES; e++) begin
                if (!found && eligible[e] && !take[e] && !(|(tgt[e] & claimed))) begin
                    found          = 1'b1;
                    take[e]        = 1'b1;
                    claimed        = claimed | tgt[e];
                    issue_valid[k] = 1'b1;
                    issue_tid[k*TID_W +: TID_W] = ent_tid[e*TID_W +: TID_W];
                    issue_aid[k*AID_W +: AID_W] = ent_aid[e*AID_W +: AID_W];
                end
            end
        end
        set_busy = claimed;
    end

endmodule

// File: rtl/rs_acc_status.sv
module rs_acc_status #(
    parameter int NUM_ACCEL = 4,
    parameter int AID_W     = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_ACCEL-1:0] set_mask,
    input  logic                 clr_valid,
    input  logic [AID_W-1:0]     clr_aid,
    output logic [NUM_ACCEL-1:0] busy_q
);

    logic [NUM_ACCEL-1:0] clr_oh;

    for (genvar a = 0; a < NUM_ACCEL; a++) begin : g_clr
        assign clr_oh[a] = clr_valid && (clr_aid == AID_W'(a));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q <= '0;
        end else begin
            busy_q <= (busy_q & ~clr_oh) | set_mask;
        end
    end

endmodule

// File: rtl/rs_ticket_arbiter.sv
module rs_ticket_arbiter
    import rs_pkg::*;
#(
    parameter int NUM_REQ = 4,
    parameter int TID_W   = 4,
    parameter int AID_W   = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_REQ-1:0]       req,
    input  logic [NUM_REQ*TID_W-1:0] req_tid,
    output logic [NUM_REQ-1:0]       grant,
    output logic                     cdb_valid,
    output logic [TID_W-1:0]         cdb_tid,
    output logic [AID_W-1:0]         cdb_aid
);

    localparam int TK_W = $clog2(NUM_REQ) + 1;

    req_state_e        state_q [NUM_REQ];
    req_state_e        state_d [NUM_REQ];
    logic [TK_W-1:0]   ticket_q [NUM_REQ];
    logic [TK_W-1:0]   tk_new [NUM_REQ];
    logic [NUM_REQ-1:0] fresh;
    logic [TK_W-1:0]   next_q, next_d;
    logic [TK_W-1:0]   serve_q;

    for (genvar i = 0; i < NUM_REQ; i++) begin : g_fresh
        assign fresh[i] = req[i] && (state_q[i] == RQ_IDLE);
        assign grant[i] = (state_q[i] == RQ_HOLD) && (ticket_q[i] == serve_q);
    end

    // Tickets for requests first seen together are numbered by index.
    always_comb begin
        logic [TK_W-1:0] cnt;
        cnt = '0;
        for (int i = 0; i < NUM_REQ; i++) begin
            tk_new[i] = next_q + cnt;
            if (fresh[i]) begin
                cnt = cnt + TK_W'(1);
            end
        end
        next_d = next_q + cnt;
    end

    for (genvar i = 0; i < NUM_REQ; i++) begin : g_req
        always_comb begin
            state_d[i] = state_q[i];
            unique case (state_q[i])
                RQ_IDLE: if (req[i])   state_d[i] = RQ_HOLD;
                RQ_HOLD: if (grant[i]) state_d[i] = RQ_IDLE;
                default: state_d[i] = RQ_IDLE;
            endcase
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                state_q[i]  <= RQ_IDLE;
                ticket_q[i] <= '0;
            end else begin
                state_q[i] <= state_d[i];
                if (fresh[i]) begin
                    ticket_q[i] <= tk_new[i];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            next_q  <= '0;
            serve_q <= '0;
        end else begin
            next_q <= next_d;
            if (|grant) begin
                serve_q <= serve_q + TK_W'(1);
            end
        end
    end

    always_comb begin
        cdb_valid = |grant;
        cdb_tid   = '0;
        cdb_aid   = '0;
        for (int i = 0; i < NUM_REQ; i++) begin
            if (grant[i]) begin
                cdb_tid = req_tid[i*TID_W +: TID_W];
                cdb_aid = AID_W'(i);
            end
        end
    end

endmodule

// File: rtl/task_rs_dispatcher.sv
module task_rs_dispatcher
    import rs_pkg::*;
#(
    parameter int ENTRIES   = 4,
    parameter int NUM_ACCEL = 4,
    parameter int ISSUE_W   = 2,
    parameter int TID_W     = DEF_TID_W,
    parameter int AID_W     = DEF_AID_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       alloc_valid,
    input  logic [TID_W-1:0]           alloc_tid,
    input  logic [AID_W-1:0]           alloc_aid,
    input  logic                       alloc_has_dep,
    input  logic [TID_W-1:0]           alloc_dep_tid,
    output logic                       alloc_stall,
    output logic [ISSUE_W-1:0]         issue_valid,
    output logic [ISSUE_W*TID_W-1:0]   issue_tid,
    output logic [ISSUE_W*AID_W-1:0]   issue_aid,
    input  logic [NUM_ACCEL-1:0]       done_req,
    input  logic [NUM_ACCEL*TID_W-1:0] done_tid,
    output logic [NUM_ACCEL-1:0]       done_grant,
    output logic                       cdb_valid,
    output logic [TID_W-1:0]           cdb_tid,
    output logic [AID_W-1:0]           cdb_aid,
    output logic [NUM_ACCEL-1:0]       acc_busy
);

    logic [ENTRIES-1:0]       ent_free;
    logic [ENTRIES-1:0]       ent_ready;
    logic [ENTRIES-1:0]       ent_take;
    logic [ENTRIES-1:0]       wr_sel;
    logic [ENTRIES*TID_W-1:0] ent_tid;
    logic [ENTRIES*AID_W-1:0] ent_aid;
    logic [NUM_ACCEL-1:0]     set_busy;

    // Lowest free entry receives the offered task.
    always_comb begin
        logic got;
        got    = 1'b0;
        wr_sel = '0;
        for (int e = 0; e < ENTRIES; e++) begin
            if (!got && ent_free[e]) begin
                got       = 1'b1;
                wr_sel[e] = 1'b1;
            end
        end
    end

    assign alloc_stall = ~|ent_free;

    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
        rs_entry #(
            .TID_W (TID_W),
            .AID_W (AID_W)
        ) u_entry (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_en      (alloc_valid && !alloc_stall && wr_sel[e]),
            .wr_tid     (alloc_tid),
            .wr_aid     (alloc_aid),
            .wr_has_dep (alloc_has_dep),
            .wr_dep     (alloc_dep_tid),
            .cdb_valid  (cdb_valid),
            .cdb_tid    (cdb_tid),
            .take       (ent_take[e]),
            .is_free    (ent_free[e]),
            .is_ready   (ent_ready[e]),
            .tid_q      (ent_tid[e*TID_W +: TID_W]),
            .aid_q      (ent_aid[e*AID_W +: AID_W])
        );
    end

    rs_issue_select #(
        .ENTRIES   (ENTRIES),
        .NUM_ACCEL (NUM_ACCEL),
        .ISSUE_W   (ISSUE_W),
        .TID_W     (TID_W),
        .AID_W     (AID_W)
    ) u_select (
        .ready       (ent_ready),
        .ent_tid     (ent_tid),
        .ent_aid     (ent_aid),
        .busy        (acc_busy),
        .take        (ent_take),
        .issue_valid (issue_valid),
        .issue_tid   (issue_tid),
        .issue_aid   (issue_aid),
        .set_busy    (set_busy)
    );

    rs_acc_status #(
        .NUM_ACCEL (NUM_ACCEL),
        .AID_W     (AID_W)
    ) u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_mask  (set_busy),
        .clr_valid (cdb_valid),
        .clr_aid   (cdb_aid),
        .busy_q    (acc_busy)
    );

    rs_ticket_arbiter #(
        .NUM_REQ (NUM_ACCEL),
        .TID_W   (TID_W),
        .AID_W   (AID_W)
    ) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (done_req),
        .req_tid   (done_tid),
        .grant     (done_grant),
        .cdb_valid (cdb_valid),
        .cdb_tid   (cdb_tid),
        .cdb_aid   (cdb_aid)
    );

endmodule

// File: rtl/rs_dispatch_checker.sv
module rs_dispatch_checker #(
    parameter int NUM_ACCEL = 4,
    parameter int ISSUE_W   = 2,
    parameter int TID_W     = 4,
    parameter int AID_W     = 8
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [ISSUE_W-1:0]       issue_valid,
    input logic [ISSUE_W*AID_W-1:0] issue_aid,
    input logic [NUM_ACCEL-1:0]     done_grant,
    input logic                     cdb_valid,
    input logic [AID_W-1:0]         cdb_aid,
    input logic [NUM_ACCEL-1:0]     acc_busy
);

    logic [NUM_ACCEL-1:0] slot_oh [ISSUE_W];
    logic [NUM_ACCEL-1:0] cdb_oh;
    logic [NUM_ACCEL-1:0] issued_oh;

    for (genvar k = 0; k < ISSUE_W; k++) begin : g_slot
        for (genvar a = 0; a < NUM_ACCEL; a++) begin : g_a
            assign slot_oh[k][a] = (issue_aid[k*AID_W +: AID_W] == AID_W'(a));
        end
    end

    for (genvar a = 0; a < NUM_ACCEL; a++) begin : g_cdb
        assign cdb_oh[a] = (cdb_aid == AID_W'(a));
    end

    always_comb begin
        issued_oh = '0;
        for (int k = 0; k < ISSUE_W; k++) begin
            if (issue_valid[k]) issued_oh = issued_oh | slot_oh[k];
        end
    end

    // R10: at most one completion served per cycle
    p_one_grant_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(done_grant));

    // R7: broadcast clears the finishing accelerator's busy bit
    p_busy_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cdb_valid && !(|(cdb_oh & issued_oh))) |=> !(|(acc_busy & $past(cdb_oh))));

    for (genvar a = 0; a < NUM_ACCEL; a++) begin : g_gp
        // R10: a grant lasts a single cycle
        p_grant_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
            done_grant[a] |=> !done_grant[a]);
    end

    for (genvar k = 0; k < ISSUE_W; k++) begin : g_chk
        // R3: never issue to a busy accelerator
        p_issue_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
            issue_valid[k] |-> !(|(acc_busy & slot_oh[k])));
        // R4: issue marks the target busy at the next edge
        p_busy_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
            issue_valid[k] |=> (|(acc_busy & $past(slot_oh[k]))));
        if (k > 0) begin : g_ord
            // R8: slots fill from slot 0 upward
            p_slot_order_r8: assert property (@(posedge clk) disable iff (!rst_n)
                issue_valid[k] |-> issue_valid[k-1]);
        end
        for (genvar j = k + 1; j < ISSUE_W; j++) begin : g_pair
            // R8: distinct accelerators within one cycle
            p_distinct_r8: assert property (@(posedge clk) disable iff (!rst_n)
                (issue_valid[k] && issue_valid[j]) |->
                (issue_aid[k*AID_W +: AID_W] != issue_aid[j*AID_W +: AID_W]));
        end
    end

endmodule

bind task_rs_dispatcher rs_dispatch_checker #(
    .NUM_ACCEL (NUM_ACCEL),
    .ISSUE_W   (ISSUE_W),
    .TID_W     (TID_W),
    .AID_W     (AID_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .issue_valid (issue_valid),
    .issue_aid   (issue_aid),
    .done_grant  (done_grant),
    .cdb_valid   (cdb_valid),
    .cdb_aid     (cdb_aid),
    .acc_busy    (acc_busy)
);

// File: tb/task_rs_dispatcher_test.sv
module task_rs_dispatcher_test;

    localparam int  NA    = 4;
    localparam int  IW    = 2;
    localparam time TCLK  = 8ns;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          alloc_valid = 1'b0;
    logic [3:0]    alloc_tid = '0;
    logic [7:0]    alloc_aid = '0;
    logic          alloc_has_dep = 1'b0;
    logic [3:0]    alloc_dep_tid = '0;
    logic          alloc_stall;
    logic [IW-1:0] issue_valid;
    logic [IW*4-1:0] issue_tid;
    logic [IW*8-1:0] issue_aid;
    logic [NA-1:0] done_req = '0;
    logic [NA*4-1:0] done_tid = '0;
    logic [NA-1:0] done_grant;
    logic          cdb_valid;
    logic [3:0]    cdb_tid;
    logic [7:0]    cdb_aid;
    logic [NA-1:0] acc_busy;

    int n_tests = 0;
    int n_fail  = 0;

    always #(TCLK/2) clk = ~clk;

    task_rs_dispatcher uut (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_tid(alloc_tid), .alloc_aid(alloc_aid),
        .alloc_has_dep(alloc_has_dep), .alloc_dep_tid(alloc_dep_tid),
        .alloc_stall(alloc_stall),
        .issue_valid(issue_valid), .issue_tid(issue_tid), .issue_aid(issue_aid),
        .done_req(done_req), .done_tid(done_tid), .done_grant(done_grant),
        .cdb_valid(cdb_valid), .cdb_tid(cdb_tid), .cdb_aid(cdb_aid),
        .acc_busy(acc_busy)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // advance past the next rising edge, to a quiet point after it
    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic alloc(input int t, input int a, input bit dep, input int p);
        alloc_valid   = 1'b1;
        alloc_tid     = 4'(t);
        alloc_aid     = 8'(a);
        alloc_has_dep = dep;
        alloc_dep_tid = 4'(p);
        tick();
        alloc_valid = 1'b0;
        #1;
    endtask

    // model accelerator a reporting task t when nothing else is queued
    task automatic complete(input int a, input int t);
        done_req[a] = 1'b1;
        done_tid[a*4 +: 4] = 4'(t);
        tick();
        #1;
        chk("R10 grant", int'(done_grant), 1 << a);
        chk("R10 cdb_tid", int'(cdb_tid), t);
        chk("R10 cdb_aid", int'(cdb_aid), a);
        done_req[a] = 1'b0;
        tick();
        #1;
    endtask

    initial begin
        #(TCLK * 150000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk("R1 stall", int'(alloc_stall), 0);
        chk("R1 busy", int'(acc_busy), 0);
        chk("R1 issue", int'(issue_valid), 0);
        chk("R1 grant", int'(done_grant), 0);
        chk("R1 cdb", int'(cdb_valid), 0);

        // R2 / R4: independent task, idle accelerator
        alloc(3, 2, 1'b0, 0);
        chk("R2 valid", int'(issue_valid), 1);
        chk("R2 tid", int'(issue_tid[3:0]), 3);
        chk("R2 aid", int'(issue_aid[7:0]), 2);
        chk("R4 busy before", int'(acc_busy), 0);
        tick(); #1;
        chk("R4 busy set", int'(acc_busy), 4'b0100);
        chk("R4 no reissue", int'(issue_valid), 0);

        // R3 / R7: blocked by a busy accelerator
        alloc(5, 2, 1'b0, 0);
        chk("R3 held", int'(issue_valid), 0);
        tick(); #1;
        chk("R3 still held", int'(issue_valid), 0);
        complete(2, 3);
        chk("R7 busy clear then R3 issue", int'(issue_valid), 1);
        chk("R3 tid", int'(issue_tid[3:0]), 5);
        tick(); #1;
        chk("R4 busy again", int'(acc_busy), 4'b0100);
        complete(2, 5);
        chk("R7 busy cleared", int'(acc_busy), 0);

        // R5: every producer ID against every broadcast ID
        for (int d = 0; d < 16; d++) begin
            for (int c = 0; c < 16; c++) begin
                alloc(1, 0, 1'b1, d);
                chk("R5 waits", int'(issue_valid), 0);
                complete(3, c);
                chk("R5 wake on match", int'(issue_valid[0]), (c == d) ? 1 : 0);
                if (c != d) begin
                    complete(3, d);
                    chk("R5 release", int'(issue_valid[0]), 1);
                end
                chk("R5 tid", int'(issue_tid[3:0]), 1);
                tick();
                complete(0, 1);
            end
        end

        // R6: broadcast in the same cycle as the write
        done_req[3] = 1'b1;
        done_tid[15:12] = 4'd7;
        tick(); #1;
        alloc_valid = 1'b1; alloc_tid = 4'd2; alloc_aid = 8'd1;
        alloc_has_dep = 1'b1; alloc_dep_tid = 4'd7;
        done_req[3] = 1'b0;
        tick();
        alloc_valid = 1'b0;
        #1;
        chk("R6 same-cycle wake", int'(issue_valid), 1);
        chk("R6 tid", int'(issue_tid[3:0]), 2);
        tick();
        complete(1, 2);
        // control: non-matching broadcast in the write cycle
        done_req[3] = 1'b1;
        done_tid[15:12] = 4'd6;
        tick(); #1;
        alloc_valid = 1'b1; alloc_tid = 4'd2; alloc_aid = 8'd1;
        alloc_has_dep = 1'b1; alloc_dep_tid = 4'd7;
        done_req[3] = 1'b0;
        tick();
        alloc_valid = 1'b0;
        #1;
        chk("R6 mismatch waits", int'(issue_valid), 0);
        complete(3, 7);
        chk("R6 later wake", int'(issue_valid), 1);
        tick();
        complete(1, 2);

        // R8 / R9: fill the station, then wake all at once
        alloc(0, 0, 1'b1, 9);
        alloc(1, 1, 1'b1, 9);
        alloc(2, 1, 1'b1, 9);
        chk("R9 not full", int'(alloc_stall), 0);
        alloc(3, 2, 1'b1, 9);
        chk("R9 full", int'(alloc_stall), 1);
        alloc(12, 3, 1'b0, 0);
        chk("R9 dropped no issue", int'(issue_valid), 0);
        chk("R9 still full", int'(alloc_stall), 1);
        complete(3, 9);
        chk("R8 two slots", int'(issue_valid), 3);
        chk("R8 slot0 tid", int'(issue_tid[3:0]), 0);
        chk("R8 slot0 aid", int'(issue_aid[7:0]), 0);
        chk("R8 slot1 tid", int'(issue_tid[7:4]), 1);
        chk("R8 slot1 aid", int'(issue_aid[15:8]), 1);
        tick(); #1;
        chk("R8 next cycle", int'(issue_valid), 1);
        chk("R8 skip same accel", int'(issue_tid[3:0]), 3);
        chk("R8 busy", int'(acc_busy), 4'b0011);
        tick(); #1;
        chk("R8 none left eligible", int'(issue_valid), 0);
        chk("R9 stall released", int'(alloc_stall), 0);
        complete(1, 1);
        chk("R8 held entry issues", int'(issue_valid), 1);
        chk("R8 held tid", int'(issue_tid[3:0]), 2);
        tick(); #1;
        chk("R9 dropped never ran", int'(acc_busy), 4'b0111);
        complete(0, 0);
        complete(1, 2);
        complete(2, 3);
        chk("R9 empty", int'(issue_valid), 0);
        chk("R9 busy idle", int'(acc_busy), 0);

        // R10: later request queued behind earlier ones
        done_req[1] = 1'b1; done_tid[7:4] = 4'd4;
        done_req[2] = 1'b1; done_tid[11:8] = 4'd5;
        tick(); #1;
        chk("R10 first", int'(done_grant), 4'b0010);
        chk("R10 first tid", int'(cdb_tid), 4);
        done_req[1] = 1'b0;
        done_req[0] = 1'b1; done_tid[3:0] = 4'd6;
        tick(); #1;
        chk("R10 second", int'(done_grant), 4'b0100);
        chk("R10 second tid", int'(cdb_tid), 5);
        done_req[2] = 1'b0;
        tick(); #1;
        chk("R10 third", int'(done_grant), 4'b0001);
        chk("R10 third aid", int'(cdb_aid), 0);
        done_req[0] = 1'b0;
        tick(); #1;
        chk("R10 drained", int'(done_grant), 0);

        // R10: every set of simultaneous requests
        for (int m = 1; m < 16; m++) begin
            for (int a = 0; a < NA; a++) begin
                done_req[a] = m[a];
                done_tid[a*4 +: 4] = 4'(a + 8);
            end
            tick(); #1;
            for (int a = 0; a < NA; a++) begin
                if (m[a]) begin
                    chk("R10 sweep grant", int'(done_grant), 1 << a);
                    chk("R10 sweep tid", int'(cdb_tid), a + 8);
                    chk("R10 sweep aid", int'(cdb_aid), a);
                    done_req[a] = 1'b0;
                    tick(); #1;
                end
            end
            chk("R10 sweep idle", int'(done_grant), 0);
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule